// File: doc/BRIEF.md
# SHA-1 Message Schedule Expander

This block turns one 512-bit message block into the eighty 32-bit schedule words that the SHA-1 compression rounds use. It hands them out one word per handshake, and each word comes with its round index. Words 0 to 15 are the block's own 32-bit slices. Each later word is built from four earlier words: they are XORed together and the result is rotated left by one bit.

Only a sliding window of the sixteen most recent words is stored. A load pulse while the block is idle captures a new block and restarts the index at 0. A consumer, typically the round datapath, takes one word per accepted `valid_o`/`ready_i` handshake. The final word is marked with `last_o`. Load pulses that arrive while a block is still being expanded are ignored.

Top module: `sha1_sched_expander`

## Requirements
- R1: After reset `valid_o` and `last_o` are low and `idx_o` is 0.
- R2: A load pulse while idle makes `valid_o` high on the next cycle with `idx_o` = 0. Word i for i in 0..15 equals `block_i[32*i+31 : 32*i]`.
- R3: For i in 16..79, word i equals rotl1(W[i-3] ^ W[i-8] ^ W[i-14] ^ W[i-16]).
- R4: The rotate is circular: bit 31 of the XOR result appears as bit 0 of the word.
- R5: Each handshake advances `idx_o` by one. Exactly 80 words (indices 0..79) are given per block, and `valid_o` is low in the cycle after word 79 is accepted.
- R6: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `word_o` and `idx_o` hold their values.
- R7: `last_o` is high exactly when `valid_o` is high and `idx_o` = 79.
- R8: A load pulse while `valid_o` is high is ignored. This includes the cycle in which word 79 is accepted. The word sequence continues unchanged.
- R9: A load after a block has completed restarts the sequence at index 0 with the new block's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load pulse, takes effect only when idle |
| block_i | input | 512 | Message block; slice i is word i |
| ready_i | input | 1 | Consumer accepts the current word |
| valid_o | output | 1 | A schedule word is presented |
| word_o | output | 32 | Current schedule word |
| idx_o | output | 7 | Round index of `word_o` |
| last_o | output | 1 | Marks word 79 |

## Verification
A window that loses or misplaces one entry first shows up at the ports only at index 16 or later. From there it keeps corrupting, because every word from 16 onward is fed back into the window through the taps. The bench therefore compares every presented word against an independently computed list of 80 words, so a single bad shift is reported within a few handshakes. Errors in the index counter or the done logic show as a wrong `idx_o`, a misplaced `last_o`, or a ninth-decade word, all in the cycle they occur. Stalls and ignored loads are checked by holding `ready_i` low and pulsing `load_i` while a block is in flight.

// File: rtl/sha1_sched_pkg.sv
package sha1_sched_pkg;
  localparam int WORD_W = 32;
  localparam int WIN_N  = 16;
  localparam int ROUNDS = 80;
  localparam int TAP_N  = 4;
  localparam int ROT    = 1;

  // distance back from the word being produced
  function automatic int tap_dist(input int k);
    case (k)
      0:       return 3;
      1:       return 8;
      2:       return 14;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/sha1_sched_window.sv
module sha1_sched_window #(
  parameter int WORD_W = sha1_sched_pkg::WORD_W,
  parameter int WIN_N  = sha1_sched_pkg::WIN_N
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [WIN_N*WORD_W-1:0]        block_i,
  input  logic                           shift_i,
  input  logic [WORD_W-1:0]              new_word_i,
  output logic [WIN_N-1:0][WORD_W-1:0]   win_o
);
  // win_o[k] holds W[i-WIN_N+k] once expansion has started
  for (genvar k = 0; k < WIN_N; k++) begin : g_slot
    logic [WORD_W-1:0] nxt;
    if (k == WIN_N - 1) begin : g_tail
      assign nxt = new_word_i;
    end else begin : g_body
      assign nxt = win_o[k+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      win_o[k] <= '0;
      else if (load_i)  win_o[k] <= block_i[k*WORD_W +: WORD_W];
      else if (shift_i) win_o[k] <= nxt;
    end
  end
endmodule

// File: rtl/sha1_sched_mix.sv
module sha1_sched_mix #(
  parameter int WORD_W = sha1_sched_pkg::WORD_W,
  parameter int WIN_N  = sha1_sched_pkg::WIN_N,
  parameter int TAP_N  = sha1_sched_pkg::TAP_N,
  parameter int ROT    = sha1_sched_pkg::ROT
) (
  input  logic [WIN_N-1:0][WORD_W-1:0] win_i,
  output logic [WORD_W-1:0]            word_o
);
  logic [TAP_N:0][WORD_W-1:0] acc;
  assign acc[0] = '0;
  for (genvar t = 0; t < TAP_N; t++) begin : g_tap
    localparam int SLOT = WIN_N - sha1_sched_pkg::tap_dist(t);
    assign acc[t+1] = acc[t] ^ win_i[SLOT];
  end
  assign word_o = {acc[TAP_N][WORD_W-1-ROT:0], acc[TAP_N][WORD_W-1 -: ROT]};
endmodule

// File: rtl/sha1_sched_ctrl.sv
module sha1_sched_ctrl #(
  parameter int ROUNDS = sha1_sched_pkg::ROUNDS,
  parameter int WIN_N  = sha1_sched_pkg::WIN_N,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic             load_en_o,
  output logic             shift_o,
  output logic             expand_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);
  localparam logic [IDX_W-1:0] WIN_IDX  = IDX_W'(WIN_N);

  logic active_q;
  logic [IDX_W-1:0] idx_q;
  logic fire;

  assign fire      = active_q & ready_i;
  assign load_en_o = load_i & ~active_q;
  assign expand_o  = idx_q >= WIN_IDX;
  assign shift_o   = fire & expand_o;
  assign valid_o   = active_q;
  assign idx_o     = idx_q;
  assign last_o    = active_q & (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (load_en_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (fire) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(idx_o));
  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_o |=> valid_o && idx_o == $past(idx_o) + 1'b1);
  assert_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !valid_o);
  assert_last_idx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o && idx_o == LAST_IDX);
  assert_load_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && load_i && !ready_i |=> idx_o == $past(idx_o));
  assert_load_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && load_i |=> valid_o && idx_o == '0);
endmodule

// File: rtl/sha1_sched_expander.sv
module sha1_sched_expander #(
  parameter int WORD_W = sha1_sched_pkg::WORD_W,
  parameter int WIN_N  = sha1_sched_pkg::WIN_N,
  parameter int ROUNDS = sha1_sched_pkg::ROUNDS,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [WIN_N*WORD_W-1:0] block_i,
  input  logic                    ready_i,
  output logic                    valid_o,
  output logic [WORD_W-1:0]       word_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    last_o
);
  localparam int SEL_W = $clog2(WIN_N);

  logic load_en, shift, expand;
  logic [WIN_N-1:0][WORD_W-1:0] win;
  logic [WORD_W-1:0] mix_word;

  sha1_sched_ctrl #(.ROUNDS(ROUNDS), .WIN_N(WIN_N), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .load_i, .ready_i,
    .valid_o, .idx_o, .last_o,
    .load_en_o(load_en), .shift_o(shift), .expand_o(expand)
  );

  sha1_sched_window #(.WORD_W(WORD_W), .WIN_N(WIN_N)) u_win (
    .clk_i, .rst_ni,
    .load_i(load_en), .block_i,
    .shift_i(shift), .new_word_i(mix_word),
    .win_o(win)
  );

  sha1_sched_mix #(.WORD_W(WORD_W), .WIN_N(WIN_N)) u_mix (
    .win_i(win), .word_o(mix_word)
  );

  // raw slices are read in place; expanded words come from the taps
  assign word_o = expand ? mix_word : win[idx_o[SEL_W-1:0]];

  assert_word_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> $stable(word_o));
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !valid_o || $past(load_i));
endmodule

// File: tb/sim_sha1_sched_expander.sv
module sim_sha1_sched_expander;
  logic clk = 0, rst_ni = 0, load_i = 0, ready_i = 0;
  logic [511:0] block_i = '0;
  logic valid_o, last_o;
  logic [31:0] word_o;
  logic [6:0] idx_o;

  always #2 clk = ~clk;

  sha1_sched_expander u0 (.clk_i(clk), .rst_ni, .load_i, .block_i, .ready_i,
                          .valid_o, .word_o, .idx_o, .last_o);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] exp_w [80];
  bit  exp_act = 0;
  int  exp_idx = 0;
  bit  stall_prev = 0;
  logic [31:0] prev_word;
  logic [6:0]  prev_idx;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic void fill(input logic [511:0] b);
    for (int i = 0; i < 16; i++) exp_w[i] = b[i*32 +: 32];
    for (int i = 16; i < 80; i++) begin
      logic [31:0] x;
      x = exp_w[i-3] ^ exp_w[i-8] ^ exp_w[i-14] ^ exp_w[i-16];
      exp_w[i] = {x[30:0], x[31]};
    end
  endfunction

  // reference model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_act = 0; exp_idx = 0; stall_prev = 0;
    end else begin
      stall_prev = exp_act && !ready_i;
      if (exp_act) begin
        if (ready_i) begin
          if (exp_idx == 79) begin exp_act = 0; exp_idx = 0; end
          else exp_idx++;
        end
      end else if (load_i) begin
        fill(block_i); exp_act = 1; exp_idx = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_ni) begin
    chk(valid_o == exp_act, "R5 valid", valid_o, exp_act);
    chk(last_o == (exp_act && exp_idx == 79), "R7 last", last_o, exp_act && exp_idx == 79);
    if (exp_act) begin
      chk(idx_o == exp_idx, "R5 idx", idx_o, exp_idx);
      chk(word_o == exp_w[exp_idx], exp_idx < 16 ? "R2 word" : "R3 word", word_o, exp_w[exp_idx]);
    end
    if (stall_prev) begin
      chk(word_o == prev_word && idx_o == prev_idx, "R6 stall", {idx_o, word_o}, {prev_idx, prev_word});
    end
    prev_word = word_o; prev_idx = idx_o;
  end

  initial begin
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    chk(0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic start(input logic [511:0] b);
    @(negedge clk); block_i = b; load_i = 1;
    @(negedge clk); load_i = 0;
    chk(valid_o && idx_o == 0, "R9 restart", {valid_o, idx_o}, 8'h80);
  endtask

  // mode: 0 ready high, 1 random ready with mid-run loads, 2 load on final accept
  task automatic drain(input int mode);
    while (exp_act) begin
      ready_i = (mode == 1) ? ($urandom_range(0, 2) != 0) : 1'b1;
      load_i  = (mode == 1) ? ($urandom_range(0, 9) == 0) : (mode == 2 && idx_o == 79); // R8
      if (mode == 1) block_i = {16{$urandom}};
      if (mode == 2 && idx_o == 16)
        chk(word_o == 32'h1, "R4 rotate wrap", word_o, 32'h1);
      @(negedge clk);
    end
    load_i = 0; ready_i = 0;
    chk(!valid_o, "R8 load at end ignored", valid_o, 0);
  endtask

  initial begin
    logic [511:0] b;
    repeat (3) @(negedge clk);
    chk(!valid_o && !last_o && idx_o == 0, "R1 reset", {valid_o, last_o, idx_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) b[i*32 +: 32] = 32'h01010101 * (i + 1) ^ 32'hA5000000;
    start(b); drain(0);
    for (int i = 0; i < 16; i++) b[i*32 +: 32] = $urandom;
    start(b); drain(1);
    b = '0; b[31] = 1'b1;
    start(b); drain(2);
    b = {16{32'hFFFF0000}};
    start(b); drain(1);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule